// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This unit adds or subtracts two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction with an implied leading one. A pulse on `start_i` loads both operands and the operation select. The unit then works through a fixed sequence of register stages:

- unpack, restore the hidden bits and order the operands by magnitude;
- shift the smaller significand right, keeping guard, round and sticky bits;
- add or subtract the significands;
- normalise the result;
- round to nearest, ties to even, and renormalise if rounding carried out;
- range-check the exponent and pack the result.

The packed result and two range flags appear together with a one-cycle `done_o` pulse. They stay on the outputs until the next operation completes.

Only zero and normal numbers are handled. An exponent field of 0 is read as zero whatever the fraction holds. Infinite, NaN and subnormal inputs are not supported. An exact zero result, whether from cancellation or from zero operands, is always produced as +0. A result whose exponent falls below the normal range is flushed to +0.

Top module: `fp_addsub`

## Requirements
- R1: With effective addition (equal signs after the operation is applied), the result is the correctly rounded sum. When the significand sum reaches [2,4), it is shifted right once and the exponent rises by one (1.5 + 1.5 = 0x40400000).
- R2: When `sub_i` is 1, the sign of `b_i` is inverted before the operation. 0.5 − 0.4375 gives exactly 0x3D800000 (1.0 × 2^-4) with no rounding error.
- R3: The aligned operand keeps the first two bits shifted out as guard and round, and the OR of all further bits as sticky. Rounding is to nearest with ties to even, for example:
  - 1.0 + 2^-24 gives 0x3F800000;
  - (1 + 2^-23) + 2^-24 gives 0x3F800002;
  - 1.0 + 1.5·2^-24 gives 0x3F800001;
  - 1.0 + (1 + 2^-23)·2^-24 gives 0x3F800001;
  - an addend more than 26 binades smaller leaves 1.0 unchanged.
- R4: If rounding carries out of the significand, the result is renormalised with the exponent raised by one (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R5: With effective subtraction, the difference is shifted left until the leading one returns to the hidden position, and the exponent drops by the shift count (1.0 − 0x3F7FFFFF = 0x33800000).
- R6: Operands of equal magnitude and opposite effective sign give +0 (0x00000000). The flags stay clear.
- R7: An operand with exponent field 0 acts as zero. x + 0 gives x, 0 − x gives −x, and (−0) + (−0) gives +0.
- R8: The result sign is that of the operand with the larger magnitude (1.0 − 4.0 = 0xC0400000, −2.0 + 0.5 = 0xBFC00000).
- R9: When the final biased exponent reaches 255 or more, including through a rounding carry, `ovf_o` is 1 and the result is infinity of the result sign (exponent 0xFF, fraction 0). `ovf_o` and `unf_o` are never both 1.
- R10: When the final biased exponent is 0 or below for a nonzero result, `unf_o` is 1 and the result is +0.
- R11: A `start_i` seen while idle raises `busy_o` on the next cycle. `done_o` is a single-cycle pulse on the sixth rising edge counted from the accepting edge, which is the first. `busy_o` is low while `done_o` is high.
- R12: While `rst_ni` is low, `busy_o`, `done_o`, `ovf_o`, `unf_o` and `result_o` are all 0.
- R13: `start_i` is ignored while `busy_o` is 1: the result in progress is unchanged and no extra operation follows. Both flags are 0 for any result that is in range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and begin; honoured only when idle |
| sub_i | input | 1 | 1 selects a_i − b_i, 0 selects a_i + b_i |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result and flags updated |
| result_o | output | 32 | Packed result, held until the next completion |
| ovf_o | output | 1 | Exponent overflow on the last result |
| unf_o | output | 1 | Exponent underflow on the last result |

## Verification
Every result and flag of an operation is due on exactly the sixth rising edge, counting the edge that accepts `start_i` as the first. In each scenario the bench raises `start_i` at a falling edge and waits a fixed number of edges. At the falling edge after the fifth edge it checks that `busy_o` is still high and `done_o` still low. At the falling edge after the sixth edge it compares `result_o`, `ovf_o` and `unf_o`. No check polls for `done_o`, so a design that is one cycle early or late fails both the timing checks and the value checks. For the ignored-start case, a second `start_i` is pulsed in the middle of an operation. The bench then confirms that the first result appears on schedule and that `busy_o` is low on the cycle after completion.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_RND,
    ST_PACK
  } fpadd_state_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int SIG_W = 24,
  parameter int SH_W  = 8
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [SIG_W+2:0] ext_o   // {significand, guard, round, sticky}
);
  localparam int W = SIG_W + 3;

  logic [W-1:0] full, shifted, lost_mask;

  always_comb begin
    full      = {sig_i, 3'b000};
    shifted   = '0;
    lost_mask = '0;
    if (32'(shamt_i) >= W) begin
      ext_o = {{(W-1){1'b0}}, |sig_i};
    end else begin
      shifted   = full >> shamt_i;
      lost_mask = ~({W{1'b1}} << shamt_i);
      ext_o     = {shifted[W-1:1], shifted[0] | (|(full & lost_mask))};
    end
  end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W    = 27,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     val_i,
  output logic [CNT_W-1:0] cnt_o
);
  // last hit while scanning upward is the highest set bit
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W+2:0] nrm_i,   // normalised {sig, g, r, s}
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o
);
  logic             lsb, grd, rest, up;
  logic [SIG_W:0]   sum;

  always_comb begin
    lsb     = nrm_i[3];
    grd     = nrm_i[2];
    rest    = nrm_i[1] | nrm_i[0];
    up      = grd & (rest | lsb);       // nearest, ties to even
    sum     = {1'b0, nrm_i[SIG_W+2:3]} + (SIG_W+1)'(up);
    carry_o = sum[SIG_W];
    sig_o   = carry_o ? sum[SIG_W:1] : sum[SIG_W-1:0];
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      sub_i,
  input  logic [EXP_W+FRAC_W:0]     a_i,
  input  logic [EXP_W+FRAC_W:0]     b_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [EXP_W+FRAC_W:0]     result_o,
  output logic                      ovf_o,
  output logic                      unf_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int SUM_W = EXT_W + 1;
  localparam int EW    = EXP_W + 2;
  localparam int LZ_W  = $clog2(EXT_W + 1);
  localparam int EMAX  = (1 << EXP_W) - 1;

  fpadd_state_e state_q;

  logic                 sgn_q, eff_sub_q, zero_q;
  logic signed [EW-1:0] exp_q;
  logic [SIG_W-1:0]     big_sig_q, sml_sig_q, rsig_q;
  logic [EXP_W-1:0]     diff_q;
  logic [EXT_W-1:0]     big_ext_q, sml_ext_q, nrm_q;
  logic [SUM_W-1:0]     sum_q;
  logic [W-1:0]         result_q;
  logic                 ovf_q, unf_q, done_q;

  // unpack and order by magnitude
  logic               b_sgn, swap;
  logic [W-1:0]       big_op, sml_op;
  logic               big_sgn, sml_sgn;
  logic [EXP_W-1:0]   big_exp, sml_exp;
  logic [SIG_W-1:0]   big_sig, sml_sig;

  always_comb begin
    b_sgn   = b_i[W-1] ^ sub_i;
    swap    = b_i[W-2:0] > a_i[W-2:0];
    big_op  = swap ? {b_sgn, b_i[W-2:0]} : a_i;
    sml_op  = swap ? a_i : {b_sgn, b_i[W-2:0]};
    big_sgn = big_op[W-1];
    sml_sgn = sml_op[W-1];
    big_exp = big_op[W-2 -: EXP_W];
    sml_exp = sml_op[W-2 -: EXP_W];
    big_sig = (big_exp != '0) ? {1'b1, big_op[FRAC_W-1:0]} : '0;
    sml_sig = (sml_exp != '0) ? {1'b1, sml_op[FRAC_W-1:0]} : '0;
  end

  logic [EXT_W-1:0] sml_aligned;
  fpadd_align #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_align (
    .sig_i  (sml_sig_q),
    .shamt_i(diff_q),
    .ext_o  (sml_aligned)
  );

  logic [LZ_W-1:0] lz;
  fpadd_lzc #(.W(EXT_W), .CNT_W(LZ_W)) u_lzc (
    .val_i(sum_q[EXT_W-1:0]),
    .cnt_o(lz)
  );

  logic [SIG_W-1:0] rnd_sig;
  logic             rnd_carry;
  fpadd_round #(.SIG_W(SIG_W)) u_round (
    .nrm_i  (nrm_q),
    .sig_o  (rnd_sig),
    .carry_o(rnd_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sgn_q     <= 1'b0;
      eff_sub_q <= 1'b0;
      zero_q    <= 1'b0;
      exp_q     <= '0;
      big_sig_q <= '0;
      sml_sig_q <= '0;
      diff_q    <= '0;
      big_ext_q <= '0;
      sml_ext_q <= '0;
      sum_q     <= '0;
      nrm_q     <= '0;
      rsig_q    <= '0;
      result_q  <= '0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sgn_q     <= big_sgn;
          eff_sub_q <= big_sgn ^ sml_sgn;
          exp_q     <= EW'(big_exp);
          big_sig_q <= big_sig;
          sml_sig_q <= sml_sig;
          diff_q    <= big_exp - sml_exp;
          state_q   <= ST_ALIGN;
        end
        ST_ALIGN: begin
          big_ext_q <= {big_sig_q, 3'b000};
          sml_ext_q <= sml_aligned;
          state_q   <= ST_ADD;
        end
        ST_ADD: begin
          sum_q   <= eff_sub_q ? {1'b0, big_ext_q} - {1'b0, sml_ext_q}
                               : {1'b0, big_ext_q} + {1'b0, sml_ext_q};
          state_q <= ST_NORM;
        end
        ST_NORM: begin
          zero_q <= 1'b0;
          if (sum_q[SUM_W-1]) begin
            nrm_q <= {sum_q[SUM_W-1:2], |sum_q[1:0]};
            exp_q <= exp_q + EW'(1);
          end else if (sum_q == '0) begin
            nrm_q  <= '0;
            zero_q <= 1'b1;
          end else begin
            nrm_q <= sum_q[EXT_W-1:0] << lz;
            exp_q <= exp_q - $signed({{(EW-LZ_W){1'b0}}, lz});
          end
          state_q <= ST_RND;
        end
        ST_RND: begin
          rsig_q  <= rnd_sig;
          exp_q   <= exp_q + EW'(rnd_carry);
          state_q <= ST_PACK;
        end
        ST_PACK: begin
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
          if (zero_q) begin
            result_q <= '0;
          end else if (exp_q >= EMAX) begin
            ovf_q    <= 1'b1;
            result_q <= {sgn_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          end else if (exp_q <= 0) begin
            unf_q    <= 1'b1;
            result_q <= '0;
          end else begin
            result_q <= {sgn_q, exp_q[EXP_W-1:0], rsig_q[FRAC_W-1:0]};
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;

  assert_busy_after_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_sub_nonneg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORM && eff_sub_q) |-> !sum_q[SUM_W-1]);
  assert_norm_lead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RND && !zero_q) |-> nrm_q[EXT_W-1]);
  assert_round_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PACK && !zero_q) |-> rsig_q[SIG_W-1]);
  assert_flags_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
  assert_ovf_inf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  assert_unf_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (result_o == '0));
endmodule

// File: tb/tb_fp_addsub.sv
`timescale 1ns/1ps
module tb_fp_addsub;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o, done_o, ovf_o, unf_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #2.5 clk_i = ~clk_i;

  fp_addsub dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // one operation: start at a falling edge, sample after the 5th and 6th rising edges
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] exp_res,
                        input logic exp_ovf, input logic exp_unf);
    @(negedge clk_i);
    a_i = a; b_i = b; sub_i = sub; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R11", "busy after start", 32'(busy_o), 32'd1);
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    chk("R11", "done early", 32'(done_o), 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R11", "done pulse", 32'(done_o), 32'd1);
    chk(req, "result", result_o, exp_res);
    chk(exp_ovf ? "R9" : "R13", "ovf", 32'(ovf_o), 32'(exp_ovf));
    chk(exp_unf ? "R10" : "R13", "unf", 32'(unf_o), 32'(exp_unf));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R12", "busy", 32'(busy_o), 32'd0);
    chk("R12", "done", 32'(done_o), 32'd0);
    chk("R12", "result", result_o, 32'd0);
    chk("R12", "flags", 32'({ovf_o, unf_o}), 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_same_sign;
    run_op("R1", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0);
    run_op("R1", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0);
  endtask

  task automatic t_subtract;
    run_op("R2", 32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, 1'b0, 1'b0);
  endtask

  task automatic t_rounding;
    run_op("R3", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_op("R3", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0);
    run_op("R3", 32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0);
    run_op("R3", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0);
    run_op("R3", 32'h3F800000, 32'h21800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
  endtask

  task automatic t_round_carry;
    run_op("R4", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
  endtask

  task automatic t_cancel_shift;
    run_op("R5", 32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 1'b0, 1'b0);
  endtask

  task automatic t_exact_zero;
    run_op("R6", 32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0);
    run_op("R6", 32'h40200000, 32'h40200000, 1'b1, 32'h00000000, 1'b0, 1'b0);
  endtask

  task automatic t_zero_ops;
    run_op("R7", 32'h40400000, 32'h00000000, 1'b0, 32'h40400000, 1'b0, 1'b0);
    run_op("R7", 32'h00000000, 32'h40400000, 1'b1, 32'hC0400000, 1'b0, 1'b0);
    run_op("R7", 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0);
  endtask

  task automatic t_sign;
    run_op("R8", 32'h3F800000, 32'h40800000, 1'b1, 32'hC0400000, 1'b0, 1'b0);
    run_op("R8", 32'hC0000000, 32'h3F000000, 1'b0, 32'hBFC00000, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;
    run_op("R9", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0);
    run_op("R9", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0);
    run_op("R9", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0);
  endtask

  task automatic t_underflow;
    run_op("R10", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1);
  endtask

  task automatic t_start_ignored;
    @(negedge clk_i);
    a_i = 32'h3F800000; b_i = 32'h40000000; sub_i = 1'b0; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    a_i = 32'h40800000; b_i = 32'h40800000; start_i = 1'b1;  // while busy
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R13", "done with busy start", 32'(done_o), 32'd1);
    chk("R13", "result kept", result_o, 32'h40400000);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R13", "no extra op", 32'(busy_o), 32'd0);
    chk("R11", "done falls", 32'(done_o), 32'd0);
    chk("R13", "result held", result_o, 32'h40400000);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_same_sign();
    t_subtract();
    t_rounding();
    t_round_carry();
    t_cancel_shift();
    t_exact_zero();
    t_zero_ops();
    t_sign();
    t_overflow();
    t_underflow();
    t_start_ignored();
    repeat (2) @(posedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule